// File: doc/BRIEF.md
# Audio Processor Control Register Receiver

This block is a write-only two-wire serial slave that sits in front of a stereo audio processing path. The serial clock and data lines are oversampled by the system clock. The block recognises START and STOP conditions and matches a fixed 7-bit device address. It then takes a register-select byte followed by one or more setting bytes. Each accepted byte is acknowledged by pulling the data line low during the ninth clock.

Eight 8-bit setting registers are presented as one flat parallel bus. They are volume/loudness, four output attenuators, bass, treble and input switching. A one-clock strobe per register marks every committed write, so that downstream gain logic can act on the change. Consecutive setting bytes in one transfer land in consecutive registers. The register pointer wraps from the last register back to the first. After power-on reset the receiver is idle and all outputs are muted.

Top module: `audio_ctl_i2c`

## Requirements
- R1: After reset, every register reads 0 except the switch register (index 7), which reads 0x80 (global mute, bit 7, set), and the data line is released (sda_oe_o low).
- R2: An address byte equal to {DEV_ADDR, 0} (0x80 by default) is acknowledged: sda_oe_o holds SDA low during the ninth SCL high phase.
- R3: An address byte with a different address or with the read bit (bit 0) set gets no acknowledge. Every further byte up to the next START is also left unacknowledged, and no register or strobe changes.
- R4: The byte after a matching address is acknowledged. Its bits 2:0 select the first register (0 volume/loudness, 1 front-right, 2 front-left, 3 rear-right, 4 rear-left, 5 bass, 6 treble, 7 switch), and its bits 7:3 have no effect.
- R5: Each following data byte is acknowledged and stored in the selected register. Register i appears on regs_o[8*i+7 : 8*i].
- R6: After each data byte the register index increments, and it wraps from 7 to 0 within a burst.
- R7: Stored values keep only their defined fields; every other bit reads 0. Register 0 keeps bits 7:0 (7 zero-cross mode, 6 loudness off, 5:0 volume). Registers 1 to 4 keep bits 5:0. Registers 5 and 6 keep bits 4:0. Register 7 keeps bit 7 (global mute) and bits 2:0 (source).
- R8: wr_stb_o[i] is high for exactly one clock for each byte committed to register i, and at most one strobe bit is high at a time.
- R9: START and STOP are SDA edges while SCL is high. A repeated START restarts the address phase. A STOP before the eighth bit of a data byte discards that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| scl_i | input | 1 | Serial clock line (asynchronous) |
| sda_i | input | 1 | Serial data line (asynchronous) |
| sda_oe_o | output | 1 | High to pull SDA low (acknowledge) |
| regs_o | output | 64 | Eight setting registers, register i in bits 8*i+7:8*i |
| wr_stb_o | output | 8 | One-clock write strobe per register |

## Verification
The bench builds the block with the default device address and the fixed eight-register map, and drives the bus at five system clocks per SCL quarter phase. At that size a set of eight bursts of 32 bytes carries every byte value from 0 to 255 once. The bursts start at every register index and wrap the pointer four times each. A second sweep of single-byte transfers passes many values through the switch register under changing upper select bits. Bad addresses, the read bit, STOP in mid-byte and repeated START are each driven, and the results are checked at the register outputs and the strobe counts.

// File: rtl/audio_ctl_i2c.sv
module audio_ctl_i2c #(
  parameter logic [6:0] DEV_ADDR = 7'h40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  output logic [63:0] regs_o,
  output logic [7:0]  wr_stb_o
);

  localparam int NREG = 8;
  localparam int PW   = $clog2(NREG);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SUB, S_DATA, S_SKIP} st_t;

  function automatic logic [7:0] keep_mask(input logic [PW-1:0] idx);
    case (idx)
      3'd0:                      keep_mask = 8'hFF;
      3'd1, 3'd2, 3'd3, 3'd4:    keep_mask = 8'h3F;
      3'd5, 3'd6:                keep_mask = 8'h1F;
      default:                   keep_mask = 8'h87;
    endcase
  endfunction

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_sy[1];
      sda_d  <= sda_sy[1];
    end
  end

  wire scl_s  = scl_sy[1];
  wire sda_s  = sda_sy[1];
  wire scl_up = scl_s & ~scl_d;
  wire scl_dn = ~scl_s & scl_d;
  wire go_c   = scl_s & scl_d & sda_d & ~sda_s;
  wire end_c  = scl_s & scl_d & ~sda_d & sda_s;

  st_t           state;
  logic [3:0]    nbits;
  logic [7:0]    shift;
  logic          ack;
  logic [PW-1:0] ptr;
  logic [7:0]    bank [NREG];
  logic [NREG-1:0] stb;

  wire receiving = (state == S_ADDR) || (state == S_SUB) || (state == S_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      nbits <= '0;
      shift <= '0;
      ack   <= 1'b0;
      ptr   <= '0;
      stb   <= '0;
      for (int i = 0; i < NREG; i++) bank[i] <= (i == NREG-1) ? 8'h80 : 8'h00;
    end else begin
      stb <= '0;
      if (go_c) begin
        state <= S_ADDR;
        nbits <= '0;
        ack   <= 1'b0;
      end else if (end_c) begin
        state <= S_IDLE;
        nbits <= '0;
        ack   <= 1'b0;
      end else if (scl_up && receiving && !ack) begin
        shift <= {shift[6:0], sda_s};
        nbits <= nbits + 4'd1;
      end else if (scl_dn) begin
        if (ack) begin
          ack   <= 1'b0;
          nbits <= '0;
        end else if (nbits == 4'd8) begin
          case (state)
            S_ADDR: begin
              if (shift == {DEV_ADDR, 1'b0}) begin
                ack   <= 1'b1;
                state <= S_SUB;
              end else begin
                state <= S_SKIP;
              end
            end
            S_SUB: begin
              ptr   <= shift[PW-1:0];
              ack   <= 1'b1;
              state <= S_DATA;
            end
            S_DATA: begin
              bank[ptr] <= shift & keep_mask(ptr);
              stb[ptr]  <= 1'b1;
              ptr       <= ptr + 1'b1;
              ack       <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign sda_oe_o = ack;
  assign wr_stb_o = stb;

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[8*g +: 8] = bank[g];
  end

endmodule

// File: rtl/audio_ctl_i2c_chk.sv
module audio_ctl_i2c_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sda_oe_o,
  input logic [63:0] regs_o,
  input logic [7:0]  wr_stb_o
);

  a_r1_reset_default: assert property (@(posedge clk)
    !rst_n |=> (regs_o == 64'h8000_0000_0000_0000) && !sda_oe_o);

  a_r8_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb_o));

  a_r5_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_o != 8'h00) |-> sda_oe_o);

  for (genvar i = 0; i < 8; i++) begin : g_reg
    localparam logic [7:0] KEEP = (i == 0) ? 8'hFF : (i <= 4) ? 8'h3F : (i <= 6) ? 8'h1F : 8'h87;

    a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o[i] |=> !wr_stb_o[i]);

    a_r5_change_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb_o[i] |-> $stable(regs_o[8*i +: 8]));

    a_r7_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (regs_o[8*i +: 8] & ~KEEP) == 8'h00);
  end

endmodule

bind audio_ctl_i2c audio_ctl_i2c_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe_o (sda_oe_o),
  .regs_o   (regs_o),
  .wr_stb_o (wr_stb_o)
);

// File: tb/sim_audio_ctl_i2c.sv
`timescale 1ns/1ps
module sim_audio_ctl_i2c;
  localparam int H = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic        sda_oe;
  logic [63:0] regs_o;
  logic [7:0]  wr_stb;
  wire sda_line = sda_m & ~sda_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_r [8];
  int stb_cnt [8];
  int exp_stb [8];

  always #5 clk = ~clk;

  audio_ctl_i2c u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .regs_o(regs_o), .wr_stb_o(wr_stb)
  );

  initial for (int i = 0; i < 8; i++) stb_cnt[i] = 0;
  always @(negedge clk)
    if (rst_n) for (int i = 0; i < 8; i++) if (wr_stb[i]) stb_cnt[i]++;

  function automatic logic [7:0] keep(input int i);
    if (i == 0) return 8'hFF;
    else if (i <= 4) return 8'h3F;
    else if (i <= 6) return 8'h1F;
    else return 8'h87;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(H);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic bus_bit(input bit b);
    sda_m = b; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(H);
  endtask

  task automatic bus_byte(input logic [7:0] b, output bit nack);
    for (int k = 7; k >= 0; k--) bus_bit(b[k]);
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H);
    nack = sda_line;
    scl_m = 1'b0; wt(H);
  endtask

  task automatic cmp_all(input string req);
    for (int i = 0; i < 8; i++)
      chk(regs_o[8*i +: 8] == exp_r[i], req, regs_o[8*i +: 8], exp_r[i]);
  endtask

  task automatic cmp_stb(input string req);
    for (int i = 0; i < 8; i++)
      chk(stb_cnt[i] == exp_stb[i], req, stb_cnt[i], exp_stb[i]);
  endtask

  initial begin
    bit na;
    for (int i = 0; i < 8; i++) begin exp_r[i] = (i == 7) ? 8'h80 : 8'h00; exp_stb[i] = 0; end
    wt(4);
    cmp_all("R1 reset value");
    chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
    rst_n = 1'b1;
    wt(4);
    cmp_all("R1 after release");

    // single writes of all ones, upper select bits set (R4, R7)
    for (int r = 0; r < 8; r++) begin
      bus_start;
      bus_byte(8'h80, na); chk(na == 1'b0, "R2 address ack", na, 0);
      bus_byte(8'hF8 | 8'(r), na); chk(na == 1'b0, "R4 select ack", na, 0);
      bus_byte(8'hFF, na); chk(na == 1'b0, "R5 data ack", na, 0);
      bus_stop;
      exp_r[r] = keep(r); exp_stb[r]++;
      cmp_all("R7 field mask");
    end

    // bursts covering every byte value, wrapping (R5, R6)
    for (int s = 0; s < 8; s++) begin
      bus_start;
      bus_byte(8'h80, na); chk(na == 1'b0, "R2 address ack", na, 0);
      bus_byte(8'(s), na); chk(na == 1'b0, "R4 select ack", na, 0);
      for (int k = 0; k < 32; k++) begin
        int r;
        logic [7:0] v;
        v = 8'(s * 32 + k);
        r = (s + k) % 8;
        bus_byte(v, na); chk(na == 1'b0, "R5 burst ack", na, 0);
        exp_r[r] = v & keep(r); exp_stb[r]++;
        chk(regs_o[8*r +: 8] == exp_r[r], "R6 auto-increment target", regs_o[8*r +: 8], exp_r[r]);
      end
      bus_stop;
      cmp_all("R6 after burst");
    end
    cmp_stb("R8 strobe count");

    // switch register value sweep with varying upper select bits (R4, R7)
    for (int k = 0; k < 86; k++) begin
      logic [7:0] v;
      v = 8'(k * 3);
      bus_start;
      bus_byte(8'h80, na);
      bus_byte((v & 8'hF8) | 8'h07, na); chk(na == 1'b0, "R4 select ack", na, 0);
      bus_byte(v, na);
      bus_stop;
      exp_r[7] = v & 8'h87; exp_stb[7]++;
      chk(regs_o[63:56] == exp_r[7], "R7 switch mask", regs_o[63:56], exp_r[7]);
    end
    cmp_stb("R8 strobe count sweep");

    // wrong address and read bit (R3)
    begin
      logic [7:0] bad [3];
      bad[0] = 8'h82; bad[1] = 8'h81; bad[2] = 8'h40;
      for (int b = 0; b < 3; b++) begin
        bus_start;
        bus_byte(bad[b], na); chk(na == 1'b1, "R3 no address ack", na, 1);
        bus_byte(8'h00, na); chk(na == 1'b1, "R3 select ignored", na, 1);
        bus_byte(8'h55, na); chk(na == 1'b1, "R3 data ignored", na, 1);
        bus_stop;
        cmp_all("R3 registers unchanged");
        cmp_stb("R3 no strobe");
      end
    end

    // STOP in the middle of a data byte (R9)
    bus_start;
    bus_byte(8'h80, na);
    bus_byte(8'h02, na);
    for (int k = 0; k < 4; k++) bus_bit(1'b0);
    bus_stop;
    cmp_all("R9 partial byte dropped");
    cmp_stb("R9 partial byte no strobe");

    // repeated START (R9)
    bus_start;
    bus_byte(8'h80, na);
    bus_byte(8'h01, na);
    bus_byte(8'h2A, na);
    exp_r[1] = 8'h2A; exp_stb[1]++;
    bus_start;
    bus_byte(8'h80, na); chk(na == 1'b0, "R9 repeated start address ack", na, 0);
    bus_byte(8'h06, na);
    bus_byte(8'hF3, na);
    exp_r[6] = 8'h13; exp_stb[6]++;
    bus_stop;
    cmp_all("R9 repeated start");
    cmp_stb("R8 final strobe count");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule